// File: doc/BRIEF.md
# Hardware Cursor Control Register Bank

This block keeps the control state of a hardware graphics cursor behind an 8-bit index/data register pair. The host first writes an index through the index port. Data writes and data reads then reach the register at that index. The stored state drives a cursor overlay engine directly:

- an enable bit and the full mode byte;
- an 11-bit screen origin for X and for Y;
- a 16-bit cursor map base, counted in 1 KiB units;
- 6-bit pattern start offsets in X and Y;
- a pixel-decode select bit;
- two colour stacks, one for the foreground and one for the background.

Three behaviours set this block apart from a plain register file:

- **Colour stacks.** Each stack sits behind a single index. Every write stores the byte at the stack pointer and then advances the pointer.
- **Pointer reset.** Reading the mode register returns both stack pointers to entry 0.
- **Y commit.** The Y low byte is held in a shadow register. It reaches the overlay only when the Y high byte is written, so the new Y origin takes effect all at once.

Top module: `curs_regbank`

## Requirements
- R1: After reset the index is 00h, and the mode, X, Y, map base, pattern offsets, Y shadow and decode select are all 0. Every foreground stack entry is FFh, every background stack entry is 00h, and both stack pointers are 0.
- R2: A pulse on `idx_we` loads `wdata` into the index on the next clock edge. `rdata` always shows, combinationally, the register addressed by the current index. Any index not listed in R3 to R10 reads 00h, and a data write to such an index changes no state.
- R3: Index 45h is an 8-bit read/write mode register. Its bit 0 drives `cur_en`.
- R4: Index 46h sets X bits 10:8 from `wdata[2:0]`, and index 47h sets X bits 7:0. Each write reaches `cur_x` right away. Reads return the stored bits, with the unused upper bits of 46h reading 0.
- R5: A write to index 49h goes only to the Y shadow and leaves `cur_y` unchanged. A write to index 48h sets `cur_y` to {`wdata[2:0]`, shadow}. Reads of 48h and 49h return the committed Y.
- R6: A data write to index 4Ah stores the byte in the foreground stack at the pointer, then moves the pointer forward by one, wrapping modulo 4. Index 4Bh does the same for the background stack. A read of either index returns the entry at that stack's pointer and leaves the pointer where it is.
- R7: A data read (`dat_re`) at index 45h clears both stack pointers at the next clock edge.
- R8: Index 4Ch holds the high byte and index 4Dh the low byte of the 16-bit map base on `map_base`. Both read back as written.
- R9: Index 4Eh holds a 6-bit X pattern offset and index 4Fh holds a 6-bit Y pattern offset. Each keeps `wdata[5:0]`, and bits 7:6 read 0.
- R10: Index 55h keeps only `wdata[4]`, which drives `alt_decode`. It reads back as 10h or 00h.
- R11: Data writes take effect on the clock edge at which the strobe is sampled. A data access in the same cycle as an `idx_we` uses the old index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_we | input | 1 | Index write strobe |
| dat_we | input | 1 | Data write strobe to the indexed register |
| dat_re | input | 1 | Data read strobe (causes read side effects) |
| wdata | input | 8 | Write data for the index or data port |
| rdata | output | 8 | Indexed register read value |
| cur_en | output | 1 | Cursor enable |
| cur_mode | output | 8 | Full mode byte |
| cur_x | output | 11 | Committed X origin |
| cur_y | output | 11 | Committed Y origin |
| map_base | output | 16 | Cursor map base in 1 KiB units |
| pat_x | output | 6 | Pattern X start offset |
| pat_y | output | 6 | Pattern Y start offset |
| alt_decode | output | 1 | Alternate pixel decode select |
| fg_colors | output | 32 | Foreground stack, entry 0 in bits 7:0 |
| bg_colors | output | 32 | Background stack, entry 0 in bits 7:0 |

## Verification
The bench drives four kinds of stimulus, and each one separates a different class of fault:

- **Directed runs of stack writes** longer than the depth. These show whether the pointer wraps and whether read-only accesses disturb it.
- **Y low-then-high and low-only sequences.** These separate a correct shadow commit from a direct write of the low byte.
- **Reads at index 45h followed by further stack writes.** These show that a read clears the pointers, whereas data writes at that index do not.
- **A long random mix** of index writes, data writes, reads and idle cycles over both valid and unmapped indexes. This exposes wrong masking, wrong read values and stray writes, since every output and `rdata` is compared with the model on every cycle.

// File: rtl/curs_pkg.sv
package curs_pkg;
    localparam logic [7:0] IX_MODE   = 8'h45;
    localparam logic [7:0] IX_XHI    = 8'h46;
    localparam logic [7:0] IX_XLO    = 8'h47;
    localparam logic [7:0] IX_YHI    = 8'h48;
    localparam logic [7:0] IX_YLO    = 8'h49;
    localparam logic [7:0] IX_FG     = 8'h4A;
    localparam logic [7:0] IX_BG     = 8'h4B;
    localparam logic [7:0] IX_MHI    = 8'h4C;
    localparam logic [7:0] IX_MLO    = 8'h4D;
    localparam logic [7:0] IX_PATX   = 8'h4E;
    localparam logic [7:0] IX_PATY   = 8'h4F;
    localparam logic [7:0] IX_DECODE = 8'h55;
    localparam int         DECODE_BIT = 4;
    localparam int         MAP_W      = 16;
endpackage

// File: rtl/curs_coord.sv
module curs_coord #(
    parameter int W         = 11,
    parameter bit SHADOW_LO = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hi,
    input  logic         wr_lo,
    input  logic [7:0]   wdata,
    output logic [W-1:0] value
);
    localparam int HI_W = W - 8;

    typedef struct packed {
        logic [W-1:0] val;
        logic [7:0]   sh;
    } coord_t;

    coord_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo) begin
            if (SHADOW_LO) st_d.sh = wdata;
            else           st_d.val[7:0] = wdata;
        end
        if (wr_hi) begin
            st_d.val[W-1:8] = wdata[HI_W-1:0];
            if (SHADOW_LO) st_d.val[7:0] = st_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.val;

    p_hi_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> value[W-1:8] == $past(wdata[HI_W-1:0]));

    generate
        if (SHADOW_LO) begin : g_shadow
            p_lo_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_lo && !wr_hi) |=> $stable(value));
        end else begin : g_direct
            p_lo_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_lo |=> value[7:0] == $past(wdata));
        end
    endgenerate
endmodule

// File: rtl/curs_stack.sv
module curs_stack #(
    parameter int         DEPTH   = 4,
    parameter logic [7:0] RST_VAL = 8'hFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               clr,
    input  logic [7:0]         wdata,
    output logic [7:0]         top,
    output logic [DEPTH*8-1:0] entries
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      ptr;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.ptr = '0;
        end else if (push) begin
            st_d.mem[st_q.ptr] = wdata;
            st_d.ptr = (st_q.ptr == LAST) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem <= {DEPTH{RST_VAL}};
            st_q.ptr <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top = st_q.mem[st_q.ptr];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_flat
            assign entries[i*8 +: 8] = st_q.mem[i];
        end
    endgenerate

    p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> st_q.ptr == '0);
    p_push_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |=> st_q.mem[$past(st_q.ptr)] == $past(wdata));
    p_ptr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !clr) |=> $stable(st_q.ptr));
endmodule

// File: rtl/curs_regbank.sv
module curs_regbank #(
    parameter int STACK_DEPTH = 4,
    parameter int COORD_W     = 11,
    parameter int PAT_W       = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     idx_we,
    input  logic                     dat_we,
    input  logic                     dat_re,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    output logic                     cur_en,
    output logic [7:0]               cur_mode,
    output logic [COORD_W-1:0]       cur_x,
    output logic [COORD_W-1:0]       cur_y,
    output logic [15:0]              map_base,
    output logic [PAT_W-1:0]         pat_x,
    output logic [PAT_W-1:0]         pat_y,
    output logic                     alt_decode,
    output logic [STACK_DEPTH*8-1:0] fg_colors,
    output logic [STACK_DEPTH*8-1:0] bg_colors
);
    import curs_pkg::*;

    localparam int HI_W = COORD_W - 8;

    typedef struct packed {
        logic [7:0]       idx;
        logic [7:0]       mode;
        logic [MAP_W-1:0] map;
        logic [PAT_W-1:0] px;
        logic [PAT_W-1:0] py;
        logic             alt;
    } bank_t;

    bank_t st_d, st_q;

    logic       wr_mode, wr_xhi, wr_xlo, wr_yhi, wr_ylo, wr_fg, wr_bg;
    logic       wr_mhi, wr_mlo, wr_px, wr_py, wr_dec, rd_mode;
    logic [7:0] fg_top, bg_top;

    always_comb begin
        wr_mode = dat_we && (st_q.idx == IX_MODE);
        wr_xhi  = dat_we && (st_q.idx == IX_XHI);
        wr_xlo  = dat_we && (st_q.idx == IX_XLO);
        wr_yhi  = dat_we && (st_q.idx == IX_YHI);
        wr_ylo  = dat_we && (st_q.idx == IX_YLO);
        wr_fg   = dat_we && (st_q.idx == IX_FG);
        wr_bg   = dat_we && (st_q.idx == IX_BG);
        wr_mhi  = dat_we && (st_q.idx == IX_MHI);
        wr_mlo  = dat_we && (st_q.idx == IX_MLO);
        wr_px   = dat_we && (st_q.idx == IX_PATX);
        wr_py   = dat_we && (st_q.idx == IX_PATY);
        wr_dec  = dat_we && (st_q.idx == IX_DECODE);
        rd_mode = dat_re && (st_q.idx == IX_MODE);
    end

    always_comb begin
        st_d = st_q;
        if (wr_mode) st_d.mode = wdata;
        if (wr_mhi)  st_d.map[MAP_W-1:8] = wdata;
        if (wr_mlo)  st_d.map[7:0] = wdata;
        if (wr_px)   st_d.px = wdata[PAT_W-1:0];
        if (wr_py)   st_d.py = wdata[PAT_W-1:0];
        if (wr_dec)  st_d.alt = wdata[DECODE_BIT];
        if (idx_we)  st_d.idx = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    curs_coord #(.W(COORD_W), .SHADOW_LO(1'b0)) u_x (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_xhi), .wr_lo(wr_xlo),
        .wdata(wdata), .value(cur_x)
    );

    curs_coord #(.W(COORD_W), .SHADOW_LO(1'b1)) u_y (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_yhi), .wr_lo(wr_ylo),
        .wdata(wdata), .value(cur_y)
    );

    curs_stack #(.DEPTH(STACK_DEPTH), .RST_VAL(8'hFF)) u_fg (
        .clk(clk), .rst_n(rst_n), .push(wr_fg), .clr(rd_mode),
        .wdata(wdata), .top(fg_top), .entries(fg_colors)
    );

    curs_stack #(.DEPTH(STACK_DEPTH), .RST_VAL(8'h00)) u_bg (
        .clk(clk), .rst_n(rst_n), .push(wr_bg), .clr(rd_mode),
        .wdata(wdata), .top(bg_top), .entries(bg_colors)
    );

    always_comb begin
        rdata = '0;
        unique case (st_q.idx)
            IX_MODE:   rdata = st_q.mode;
            IX_XHI:    rdata[HI_W-1:0] = cur_x[COORD_W-1:8];
            IX_XLO:    rdata = cur_x[7:0];
            IX_YHI:    rdata[HI_W-1:0] = cur_y[COORD_W-1:8];
            IX_YLO:    rdata = cur_y[7:0];
            IX_FG:     rdata = fg_top;
            IX_BG:     rdata = bg_top;
            IX_MHI:    rdata = st_q.map[MAP_W-1:8];
            IX_MLO:    rdata = st_q.map[7:0];
            IX_PATX:   rdata[PAT_W-1:0] = st_q.px;
            IX_PATY:   rdata[PAT_W-1:0] = st_q.py;
            IX_DECODE: rdata[DECODE_BIT] = st_q.alt;
            default:   rdata = '0;
        endcase
    end

    assign cur_en     = st_q.mode[0];
    assign cur_mode   = st_q.mode;
    assign map_base   = st_q.map;
    assign pat_x      = st_q.px;
    assign pat_y      = st_q.py;
    assign alt_decode = st_q.alt;

    p_idx_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> st_q.idx == $past(wdata));
    p_mode_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> cur_en == $past(wdata[0]));
    p_map_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mlo |=> map_base[7:0] == $past(wdata));
    p_decode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dec |=> alt_decode == $past(wdata[DECODE_BIT]));
    p_pat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_we |=> $stable(pat_x) && $stable(pat_y));
endmodule

// File: tb/tb_curs_regbank.sv
module tb_curs_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_we = 1'b0, dat_we = 1'b0, dat_re = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        cur_en, alt_decode;
    logic [7:0]  cur_mode;
    logic [10:0] cur_x, cur_y;
    logic [15:0] map_base;
    logic [5:0]  pat_x, pat_y;
    logic [31:0] fg_colors, bg_colors;

    int n_vec = 0, n_bad = 0;

    always #10 clk = ~clk;

    curs_regbank dut (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re),
        .wdata(wdata), .rdata(rdata), .cur_en(cur_en), .cur_mode(cur_mode),
        .cur_x(cur_x), .cur_y(cur_y), .map_base(map_base), .pat_x(pat_x), .pat_y(pat_y),
        .alt_decode(alt_decode), .fg_colors(fg_colors), .bg_colors(bg_colors)
    );

    // behavioural reference model
    int m_idx, m_mode, m_x, m_y, m_ysh, m_map, m_px, m_py, m_alt, m_fp, m_bp;
    int m_fg[4];
    int m_bg[4];

    task automatic m_reset();
        m_idx = 0; m_mode = 0; m_x = 0; m_y = 0; m_ysh = 0; m_map = 0;
        m_px = 0; m_py = 0; m_alt = 0; m_fp = 0; m_bp = 0;
        for (int i = 0; i < 4; i++) begin m_fg[i] = 255; m_bg[i] = 0; end
    endtask

    function automatic int m_read(int ix);
        case (ix)
            'h45: return m_mode;
            'h46: return m_x >> 8;
            'h47: return m_x & 255;
            'h48: return m_y >> 8;
            'h49: return m_y & 255;
            'h4A: return m_fg[m_fp];
            'h4B: return m_bg[m_bp];
            'h4C: return m_map >> 8;
            'h4D: return m_map & 255;
            'h4E: return m_px;
            'h4F: return m_py;
            'h55: return m_alt << 4;
            default: return 0;
        endcase
    endfunction

    initial m_reset();

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reset();
        end else begin
            automatic int d = int'(wdata);
            if (dat_we) begin
                case (m_idx)
                    'h45: m_mode = d;
                    'h46: m_x = (m_x & 255) | ((d & 7) << 8);
                    'h47: m_x = (m_x & 'h700) | d;
                    'h48: m_y = ((d & 7) << 8) | m_ysh;
                    'h49: m_ysh = d;
                    'h4A: begin m_fg[m_fp] = d; m_fp = (m_fp + 1) % 4; end
                    'h4B: begin m_bg[m_bp] = d; m_bp = (m_bp + 1) % 4; end
                    'h4C: m_map = (m_map & 255) | (d << 8);
                    'h4D: m_map = (m_map & 'hFF00) | d;
                    'h4E: m_px = d & 63;
                    'h4F: m_py = d & 63;
                    'h55: m_alt = (d >> 4) & 1;
                    default: ;
                endcase
            end
            if (dat_re && m_idx == 'h45) begin m_fp = 0; m_bp = 0; end
            if (idx_we) m_idx = d;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 rdata", int'(rdata), m_read(m_idx));
            check("R3 cur_en", int'(cur_en), m_mode & 1);
            check("R3 cur_mode", int'(cur_mode), m_mode);
            check("R4 cur_x", int'(cur_x), m_x);
            check("R5 cur_y", int'(cur_y), m_y);
            check("R8 map_base", int'(map_base), m_map);
            check("R9 pat_x", int'(pat_x), m_px);
            check("R9 pat_y", int'(pat_y), m_py);
            check("R10 alt_decode", int'(alt_decode), m_alt);
            for (int i = 0; i < 4; i++) begin
                check("R6 fg entry", int'(fg_colors[i*8 +: 8]), m_fg[i]);
                check("R6 bg entry", int'(bg_colors[i*8 +: 8]), m_bg[i]);
            end
        end
    end

    task automatic drive(logic iw, logic dw, logic dr, logic [7:0] v);
        @(negedge clk);
        #2;
        idx_we = iw; dat_we = dw; dat_re = dr; wdata = v;
    endtask

    task automatic set_idx(logic [7:0] v); drive(1'b1, 1'b0, 1'b0, v); endtask
    task automatic wr(logic [7:0] v);      drive(1'b0, 1'b1, 1'b0, v); endtask
    task automatic rd();                   drive(1'b0, 1'b0, 1'b1, 8'h00); endtask
    task automatic idle();                 drive(1'b0, 1'b0, 1'b0, 8'h00); endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    logic [7:0] pool [16] = '{8'h45, 8'h46, 8'h47, 8'h48, 8'h49, 8'h4A, 8'h4B, 8'h4C,
                              8'h4D, 8'h4E, 8'h4F, 8'h55, 8'h00, 8'h50, 8'h44, 8'hFF};

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        idle();
        // R1: reset state
        @(negedge clk); #1;
        check("R1 fg reset", int'(fg_colors), 32'hFFFF_FFFF);
        check("R1 bg reset", int'(bg_colors), 0);
        check("R1 x/y reset", int'({cur_x, cur_y}), 0);
        check("R1 rdata idx0", int'(rdata), 0);

        // R11: write lands on the sampling edge
        set_idx(8'h47); wr(8'h5A); idle();
        @(negedge clk); #1;
        check("R11 x low after edge", int'(cur_x[7:0]), 8'h5A);
        set_idx(8'h46); wr(8'hFF); idle();

        // R5: low byte to shadow only, high byte commits
        set_idx(8'h49); wr(8'h33); idle();
        @(negedge clk); #1;
        check("R5 y unchanged by low", int'(cur_y), 0);
        set_idx(8'h48); wr(8'hF5); idle();
        @(negedge clk); #1;
        check("R5 y committed", int'(cur_y), 11'h533);

        // R6: stack wrap beyond depth
        set_idx(8'h4A);
        for (int i = 0; i < 6; i++) wr(8'(8'h10 + i));
        rd(); rd(); idle();
        set_idx(8'h4B);
        for (int i = 0; i < 5; i++) wr(8'(8'hA0 + i));

        // R7: mode read clears pointers, mode write does not
        set_idx(8'h45); wr(8'h01); rd(); idle();
        set_idx(8'h4A); wr(8'hC3); idle();
        @(negedge clk); #1;
        check("R7 fg entry0 after clear", int'(fg_colors[7:0]), 8'hC3);

        // R8/R9/R10/R2 directed
        set_idx(8'h4C); wr(8'h12); set_idx(8'h4D); wr(8'h34);
        set_idx(8'h4E); wr(8'hFF); set_idx(8'h4F); wr(8'hC7);
        set_idx(8'h55); wr(8'hEF); wr(8'h10);
        set_idx(8'h50); wr(8'h99); idle();
        // R11: data access together with index write uses old index
        set_idx(8'h4E); drive(1'b1, 1'b1, 1'b0, 8'h4F); idle();

        // random mix
        for (int n = 0; n < 3000; n++) begin
            automatic int op = int'($urandom % 4);
            case (op)
                0: set_idx(pool[$urandom % 16]);
                1: wr(8'($urandom));
                2: rd();
                default: idle();
            endcase
        end
        idle(); idle();
        finish_run();
    end
endmodule